// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block turns a host command request into the register writes that launch a command on an SD card controller's command path, then watches for the card-side events that end the command. A request carries a 6-bit opcode, a 32-bit argument, a response kind and two data-phase flags. The engine builds a 16-bit command word from them. It writes the argument as two 16-bit halves and then the command word, one write per cycle.

After the command word is written, the engine keeps a sticky status register that card-side event pulses set. It polls that register every cycle and services the first event in a fixed priority order. Servicing an event clears only that event's bits and ends the command with a result code. On response end, the 32-bit response is captured. If no event arrives within a bounded number of polls, the command ends with a timeout result. A response kind the engine cannot encode is rejected at once, and nothing is written. A request that arrives while a command is outstanding is refused.

Top module: `sd_cmd_issue`

## Requirements
- R1: The command word holds the opcode in bits 5:0 and a response code in bits 10:8. The code depends on the response kind: none (kind 0) gives 3, R1/R6 (kind 1) gives 4, R1b (kind 2) gives 5, R2 (kind 3) gives 6 and R3 (kind 4) gives 7. Bits 7:6 and 15:13 are zero.
- R2: Bit 11 of the command word is set when a data phase follows. Bit 12 is set when that data moves from card to host.
- R3: A request with response kind 5, 6 or 7 produces `done_o` with result 5 (rejected) in the next cycle, and no write is issued.
- R4: An accepted request issues three writes in the three cycles right after acceptance. They go in order: argument bits 15:0 at ARG_OFS, argument bits 31:16 at ARG_OFS+2, then the command word at CMD_OFS.
- R5: Accepting a request clears any stale response-end status bit, so that bit cannot end the new command.
- R6: While waiting, pending status is serviced in this order: any error bit first (result 3), then response end (result 0), then receive-ready (result 1), then data end (result 2). `done_o` pulses one cycle after the servicing edge.
- R7: Servicing clears only the serviced event: all error bits for an error, otherwise the single serviced bit. The other status bits stay set.
- R8: When response end is serviced, the value on `rsp_i` at that edge appears on `rsp_o` together with `done_o`.
- R9: If no event is pending for TIMEOUT_POLLS consecutive wait cycles, the command ends with result 4 (timeout).
- R10: A request that arrives while `busy_o` is high is ignored. `refused_o` pulses in the next cycle, and the outstanding command goes on unchanged.
- R11: Status bits are set by one-cycle pulses on `evt_i` and stay set until serviced. The bits are: bit 0 response end, bit 1 data end, bit 2 receive-ready, and bits 3..11 errors (command index, CRC, stop bit, data timeout, receive overflow, transmit underrun, command timeout, illegal access, illegal function). After reset, status, busy and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_opcode_i | input | OPC_W | Command opcode |
| req_arg_i | input | 32 | Command argument |
| req_rsp_kind_i | input | 3 | Response kind (0..4 valid) |
| req_data_i | input | 1 | Data phase follows |
| req_read_i | input | 1 | Data moves from card to host |
| busy_o | output | 1 | Command outstanding |
| refused_o | output | 1 | Previous-cycle request refused as busy |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| result_o | output | 3 | 0 rsp end, 1 rx ready, 2 data end, 3 error, 4 timeout, 5 rejected |
| rsp_o | output | 32 | Captured response |
| cmd_wr_o | output | 1 | Command-path write strobe |
| cmd_addr_o | output | ADDR_W | Command-path write offset |
| cmd_wdata_o | output | 16 | Command-path write data |
| evt_i | input | 12 | Card-side event pulses |
| rsp_i | input | 32 | Card-side response value |
| status_o | output | 12 | Sticky status bits |

## Verification
The request is driven in cycle c. The three writes are due in cycles c+1, c+2 and c+3, and the first poll happens in cycle c+4. An event pulsed in cycle k therefore finishes the command at cycle max(c+5, k+2). A timeout finishes at c+4+TIMEOUT_POLLS, a rejection at c+1, and a refusal is reported at one cycle past the refused request. The driver task works out each of these due cycles and queues it with the expected value. The monitor samples on the falling edge and compares both the value and the cycle counter, so an early or late output fails just as a wrong value does.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;
  localparam int WORD_W   = 16;
  localparam int ARG_W    = 32;
  localparam int RSP_W    = 32;
  localparam int STAT_W   = 12;
  localparam int CODE_LSB = 8;
  localparam int DATA_BIT = 11;
  localparam int READ_BIT = 12;
  localparam logic [2:0] CODE_BASE = 3'd3;
  localparam logic [2:0] KIND_MAX  = 3'd4;

  localparam int SB_RSP_END  = 0;
  localparam int SB_DATA_END = 1;
  localparam int SB_RX_RDY   = 2;
  localparam logic [STAT_W-1:0] ERR_MASK = 12'hFF8;

  typedef enum logic [2:0] {
    RES_RSP   = 3'd0,
    RES_RXRDY = 3'd1,
    RES_DEND  = 3'd2,
    RES_ERR   = 3'd3,
    RES_TMO   = 3'd4,
    RES_REJ   = 3'd5
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARG_LO, ST_ARG_HI, ST_CMD, ST_WAIT
  } state_e;
endpackage

// File: rtl/sd_cmd_word.sv
`timescale 1ns/1ps
module sd_cmd_word
  import sd_cmd_pkg::*;
#(
  parameter int unsigned OPC_W = 6
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [2:0]        kind_i,
  input  logic              data_i,
  input  logic              read_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ok_o
);
  logic [2:0] code;

  always_comb begin
    ok_o = (kind_i <= KIND_MAX);
    code = kind_i + CODE_BASE;
    word_o = '0;
    word_o[OPC_W-1:0] = opcode_i;
    word_o[CODE_LSB +: 3] = code;
    word_o[DATA_BIT] = data_i;
    word_o[READ_BIT] = read_i;
  end
endmodule

// File: rtl/sd_evt_status.sv
`timescale 1ns/1ps
module sd_evt_status
  import sd_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_stale_i,
  input  logic              service_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              pending_o,
  output result_e           pick_o
);
  logic [STAT_W-1:0] clr_pick, clr_all;

  // fixed service order: errors, response end, rx ready, data end
  always_comb begin
    clr_pick  = '0;
    pick_o    = RES_RSP;
    pending_o = 1'b1;
    if (|(stat_o & ERR_MASK)) begin
      pick_o   = RES_ERR;
      clr_pick = stat_o & ERR_MASK;
    end else if (stat_o[SB_RSP_END]) begin
      pick_o = RES_RSP;
      clr_pick[SB_RSP_END] = 1'b1;
    end else if (stat_o[SB_RX_RDY]) begin
      pick_o = RES_RXRDY;
      clr_pick[SB_RX_RDY] = 1'b1;
    end else if (stat_o[SB_DATA_END]) begin
      pick_o = RES_DEND;
      clr_pick[SB_DATA_END] = 1'b1;
    end else begin
      pending_o = 1'b0;
    end
    clr_all = service_i ? clr_pick : '0;
    if (clr_stale_i) clr_all[SB_RSP_END] = 1'b1;
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_bit
    logic bit_q;
    // a fresh event in the clearing cycle survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q & ~clr_all[g]) | set_i[g];
    end
    assign stat_o[g] = bit_q;
  end
endmodule

// File: rtl/sd_poll_timer.sv
`timescale 1ns/1ps
module sd_poll_timer #(
  parameter int unsigned LIMIT = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (expired_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_cmd_issue.sv
`timescale 1ns/1ps
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int unsigned OPC_W         = 6,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned ARG_OFS       = 0,
  parameter int unsigned CMD_OFS       = 4,
  parameter int unsigned TIMEOUT_POLLS = 10_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [OPC_W-1:0]  req_opcode_i,
  input  logic [ARG_W-1:0]  req_arg_i,
  input  logic [2:0]        req_rsp_kind_i,
  input  logic              req_data_i,
  input  logic              req_read_i,
  output logic              busy_o,
  output logic              refused_o,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic [RSP_W-1:0]  rsp_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [WORD_W-1:0] cmd_wdata_o,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [RSP_W-1:0]  rsp_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned HALF_W = ARG_W / 2;
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(ARG_OFS);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(ARG_OFS + HALF_W / 8);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFS);

  state_e            state_q;
  logic [ARG_W-1:0]  arg_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q, refused_q;
  result_e           result_q;
  logic [RSP_W-1:0]  rsp_q;

  logic [WORD_W-1:0] word_c;
  logic              word_ok;
  logic              accept, reject, in_wait;
  logic              pending, expired;
  result_e           pick;

  sd_cmd_word #(.OPC_W(OPC_W)) u_word (
    .opcode_i (req_opcode_i),
    .kind_i   (req_rsp_kind_i),
    .data_i   (req_data_i),
    .read_i   (req_read_i),
    .word_o   (word_c),
    .ok_o     (word_ok)
  );

  assign in_wait = (state_q == ST_WAIT);
  assign accept  = (state_q == ST_IDLE) && req_valid_i && word_ok;
  assign reject  = (state_q == ST_IDLE) && req_valid_i && !word_ok;

  sd_evt_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (evt_i),
    .clr_stale_i (accept),
    .service_i   (in_wait),
    .stat_o      (status_o),
    .pending_o   (pending),
    .pick_o      (pick)
  );

  sd_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (in_wait && !pending),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      arg_q     <= '0;
      word_q    <= '0;
      done_q    <= 1'b0;
      refused_q <= 1'b0;
      result_q  <= RES_RSP;
      rsp_q     <= '0;
    end else begin
      done_q    <= 1'b0;
      refused_q <= req_valid_i && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            arg_q   <= req_arg_i;
            word_q  <= word_c;
            state_q <= ST_ARG_LO;
          end else if (reject) begin
            done_q   <= 1'b1;
            result_q <= RES_REJ;
          end
        end
        ST_ARG_LO: state_q <= ST_ARG_HI;
        ST_ARG_HI: state_q <= ST_CMD;
        ST_CMD:    state_q <= ST_WAIT;
        ST_WAIT: begin
          if (pending) begin
            done_q   <= 1'b1;
            result_q <= pick;
            if (pick == RES_RSP) rsp_q <= rsp_i;
            state_q  <= ST_IDLE;
          end else if (expired) begin
            done_q   <= 1'b1;
            result_q <= RES_TMO;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_wr_o    = 1'b0;
    cmd_addr_o  = A_LO;
    cmd_wdata_o = arg_q[HALF_W-1:0];
    case (state_q)
      ST_ARG_LO: cmd_wr_o = 1'b1;
      ST_ARG_HI: begin
        cmd_wr_o    = 1'b1;
        cmd_addr_o  = A_HI;
        cmd_wdata_o = arg_q[ARG_W-1:HALF_W];
      end
      ST_CMD: begin
        cmd_wr_o    = 1'b1;
        cmd_addr_o  = A_CMD;
        cmd_wdata_o = word_q;
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign refused_o = refused_q;
  assign done_o    = done_q;
  assign result_o  = result_q;
  assign rsp_o     = rsp_q;
endmodule

// File: rtl/sd_cmd_issue_chk.sv
`timescale 1ns/1ps
module sd_cmd_issue_chk
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned ARG_OFS = 0,
  parameter int unsigned CMD_OFS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_rsp_kind_i,
  input logic              busy_o,
  input logic              refused_o,
  input logic              done_o,
  input logic [2:0]        result_o,
  input logic              cmd_wr_o,
  input logic [ADDR_W-1:0] cmd_addr_o
);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(ARG_OFS);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(ARG_OFS + 2);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFS);

  a_r3_reject_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_rsp_kind_i > KIND_MAX)
      |=> (done_o && result_o == 3'(RES_REJ) && !cmd_wr_o));

  a_r4_hi_before_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_o && cmd_addr_o == A_CMD) |-> ($past(cmd_wr_o) && $past(cmd_addr_o) == A_HI));

  a_r4_lo_before_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_o && cmd_addr_o == A_HI) |-> ($past(cmd_wr_o) && $past(cmd_addr_o) == A_LO));

  a_r10_refuse_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> refused_o);

  a_r10_idle_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_timeout_follows_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == 3'(RES_TMO)) |-> $past(busy_o));
endmodule

bind sd_cmd_issue sd_cmd_issue_chk #(
  .ADDR_W  (ADDR_W),
  .ARG_OFS (ARG_OFS),
  .CMD_OFS (CMD_OFS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_rsp_kind_i (req_rsp_kind_i),
  .busy_o         (busy_o),
  .refused_o      (refused_o),
  .done_o         (done_o),
  .result_o       (result_o),
  .cmd_wr_o       (cmd_wr_o),
  .cmd_addr_o     (cmd_addr_o)
);

// File: tb/sd_cmd_issue_test.sv
`timescale 1ns/1ps
module sd_cmd_issue_test;
  import sd_cmd_pkg::*;

  localparam int T = 16;
  localparam logic [11:0] E_RSP  = 12'h001;
  localparam logic [11:0] E_DEND = 12'h002;
  localparam logic [11:0] E_RX   = 12'h004;
  localparam logic [11:0] E_CRC  = 12'h010;
  localparam logic [11:0] E_CTO  = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_arg = '0;
  logic [2:0]  req_kind = '0;
  logic        req_d = 1'b0, req_r = 1'b0;
  logic        busy_o, refused_o, done_o, cmd_wr_o;
  logic [2:0]  result_o;
  logic [31:0] rsp_o;
  logic [7:0]  cmd_addr_o;
  logic [15:0] cmd_wdata_o;
  logic [11:0] evt = '0;
  logic [31:0] rsp_in = '0;
  logic [11:0] status_o;

  always #10 clk = ~clk;

  sd_cmd_issue #(.TIMEOUT_POLLS(T)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_opcode_i(req_op), .req_arg_i(req_arg),
    .req_rsp_kind_i(req_kind), .req_data_i(req_d), .req_read_i(req_r),
    .busy_o(busy_o), .refused_o(refused_o), .done_o(done_o),
    .result_o(result_o), .rsp_o(rsp_o),
    .cmd_wr_o(cmd_wr_o), .cmd_addr_o(cmd_addr_o), .cmd_wdata_o(cmd_wdata_o),
    .evt_i(evt), .rsp_i(rsp_in), .status_o(status_o)
  );

  typedef struct {
    bit          is_done;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [2:0]  res;
    logic [31:0] rsp;
    int          due;
    string       tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard whenever the design produces a result
  always @(negedge clk) begin
    item_t it;
    if (rst_n && (cmd_wr_o || done_o)) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R4", "unexpected output", {30'd0, cmd_wr_o, done_o}, 32'd0);
      end else begin
        it = sbq.pop_front();
        chk(it.is_done == done_o && it.is_done != cmd_wr_o, it.tag, "output kind",
            {30'd0, cmd_wr_o, done_o}, {30'd0, !it.is_done, it.is_done});
        chk(cyc == it.due, it.tag, "due cycle", cyc, it.due);
        if (it.is_done) begin
          chk(result_o == it.res, it.tag, "result", {29'd0, result_o}, {29'd0, it.res});
          if (it.res == 3'(RES_RSP))
            chk(rsp_o == it.rsp, it.tag, "response", rsp_o, it.rsp);
        end else begin
          chk(cmd_addr_o == it.addr, it.tag, "write addr", {24'd0, cmd_addr_o}, {24'd0, it.addr});
          chk(cmd_wdata_o == it.data, it.tag, "write data", {16'd0, cmd_wdata_o}, {16'd0, it.data});
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_wr(string tag, logic [7:0] a, logic [15:0] d, int due);
    item_t it;
    it.is_done = 1'b0; it.addr = a; it.data = d; it.res = '0; it.rsp = '0;
    it.due = due; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic push_done(string tag, logic [2:0] res, logic [31:0] rsp, int due);
    item_t it;
    it.is_done = 1'b1; it.addr = '0; it.data = '0; it.res = res; it.rsp = rsp;
    it.due = due; it.tag = tag;
    sbq.push_back(it);
  endtask

  // drive one request; returns the cycle it was presented in
  task automatic issue(logic [5:0] op, logic [31:0] arg, logic [2:0] kind,
                       logic d, logic r, output int c);
    logic [2:0]  code;
    logic [15:0] w;
    c = cyc;
    code = kind + 3'd3;
    w = {3'b000, r, d, code, 2'b00, op};
    req_op = op; req_arg = arg; req_kind = kind; req_d = d; req_r = r;
    req_valid = 1'b1;
    if (kind <= 3'd4) begin
      push_wr("R4", 8'd0, arg[15:0], c + 1);
      push_wr("R4", 8'd2, arg[31:16], c + 2);
      push_wr("R1/R2", 8'd4, w, c + 3);
    end else begin
      push_done("R3", 3'(RES_REJ), '0, c + 1);
    end
    step(1);
    req_valid = 1'b0;
  endtask

  function automatic int due_of(int c, int k);
    return (k + 2 > c + 5) ? k + 2 : c + 5;
  endfunction

  task automatic pulse(logic [11:0] m);
    evt = m;
    step(1);
    evt = '0;
  endtask

  task automatic wait_idle();
    while (busy_o) step(1);
    step(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11: reset state
    chk(!busy_o && !done_o && !cmd_wr_o && !refused_o, "R11", "reset outputs",
        {28'd0, busy_o, done_o, cmd_wr_o, refused_o}, 32'd0);
    chk(status_o == '0, "R11", "reset status", {20'd0, status_o}, 32'd0);

    // R1 R2 R8: read with data, response end after writes
    rsp_in = 32'hCAFE0001;
    issue(6'd17, 32'h12345678, 3'd1, 1'b1, 1'b1, c);
    step(2);
    push_done("R8", 3'(RES_RSP), 32'hCAFE0001, due_of(c, cyc));
    pulse(E_RSP);
    wait_idle();
    chk(rsp_o == 32'hCAFE0001, "R8", "held response", rsp_o, 32'hCAFE0001);

    // R1 R2: every valid kind, flag mixes, event during writes
    for (int k = 0; k < 5; k++) begin
      rsp_in = 32'hA5000000 + k;
      issue(6'(8 + k), {4{8'(k + 1)}}, 3'(k), k[0], k[1], c);
      push_done("R1", 3'(RES_RSP), 32'hA5000000 + k, due_of(c, cyc));
      pulse(E_RSP);
      wait_idle();
    end

    // R3: invalid kinds rejected with no writes
    for (int k = 5; k < 8; k++) begin
      issue(6'd33, 32'hFFFF0000, 3'(k), 1'b0, 1'b0, c);
      step(1);
      chk(!busy_o, "R3", "idle after reject", {31'd0, busy_o}, 32'd0);
    end

    // R11 sticky, R5 stale clear, R9 timeout
    pulse(E_RSP);
    chk(status_o == E_RSP, "R11", "status set", {20'd0, status_o}, {20'd0, E_RSP});
    step(3);
    chk(status_o == E_RSP, "R11", "status sticky", {20'd0, status_o}, {20'd0, E_RSP});
    issue(6'd7, 32'h00000042, 3'd1, 1'b0, 1'b0, c);
    chk(status_o == '0, "R5", "stale cleared", {20'd0, status_o}, 32'd0);
    push_done("R9", 3'(RES_TMO), '0, c + 4 + T);
    wait_idle();

    // R6 R7: error beats all, then rx ready, then data end
    issue(6'd12, 32'h0, 3'd4, 1'b0, 1'b0, c);
    push_done("R6", 3'(RES_ERR), '0, due_of(c, cyc));
    pulse(E_RSP | E_DEND | E_RX | E_CRC | E_CTO);
    wait_idle();
    chk(status_o == (E_RSP | E_DEND | E_RX), "R7", "after error",
        {20'd0, status_o}, {20'd0, E_RSP | E_DEND | E_RX});
    issue(6'd13, 32'h1, 3'd1, 1'b1, 1'b1, c);
    push_done("R6", 3'(RES_RXRDY), '0, c + 5);
    wait_idle();
    chk(status_o == E_DEND, "R7", "after rx ready", {20'd0, status_o}, {20'd0, E_DEND});
    issue(6'd14, 32'h2, 3'd1, 1'b1, 1'b1, c);
    push_done("R6", 3'(RES_DEND), '0, c + 5);
    wait_idle();
    chk(status_o == '0, "R7", "after data end", {20'd0, status_o}, 32'd0);

    // R6 R7: response end beats rx ready
    rsp_in = 32'h0BADF00D;
    issue(6'd15, 32'h3, 3'd2, 1'b0, 1'b0, c);
    push_done("R6", 3'(RES_RSP), 32'h0BADF00D, due_of(c, cyc));
    pulse(E_RSP | E_RX);
    wait_idle();
    chk(status_o == E_RX, "R7", "rx kept", {20'd0, status_o}, {20'd0, E_RX});
    issue(6'd16, 32'h4, 3'd1, 1'b0, 1'b0, c);
    push_done("R6", 3'(RES_RXRDY), '0, c + 5);
    wait_idle();

    // R10: request during busy refused, original command intact
    rsp_in = 32'h600DD00D;
    issue(6'd20, 32'hDEADBEEF, 3'd3, 1'b0, 1'b0, c);
    chk(!refused_o, "R10", "no refuse on accept", {31'd0, refused_o}, 32'd0);
    req_op = 6'd63; req_arg = 32'h11111111; req_kind = 3'd1;
    req_valid = 1'b1;
    step(1);
    req_valid = 1'b0;
    chk(refused_o, "R10", "refused pulse", {31'd0, refused_o}, 32'd1);
    push_done("R10", 3'(RES_RSP), 32'h600DD00D, due_of(c, cyc));
    pulse(E_RSP);
    chk(!refused_o, "R10", "refuse one cycle", {31'd0, refused_o}, 32'd0);
    wait_idle();

    step(2);
    chk(sbq.size() == 0, "R4", "scoreboard drained", sbq.size(), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule